// File: doc/BRIEF.md
# Bus Address Window Decoder

This block sorts every bus access by address. An access from the local bus is compared against three programmable mapping windows, one for each address space: 32-bit, 24-bit, and the lower 48 KB of the 16-bit space. It is also compared against a fixed configuration window that covers the top 16 KB of the 16-bit space. An access that hits a window is forwarded outward to the remote extension bus. An access that lands in the configuration window selects the card's own registers. Any other access is ignored.

The same windows are applied in the opposite direction to accesses arriving from the remote bus. A remote address in a supported space maps inward when it is not claimed by that space's outward window, and it selects the configuration registers when it falls in the configuration window. The window bases and masks come from registers held elsewhere. The decode runs on every strobed access and is compared afresh each time. Results are registered one cycle after the strobe is sampled.

Top module: `bus_window_decoder`

## Requirements
- R1: The address modifier selects the space. Codes 0x29 and 0x2D are the 16-bit space. Codes 0x39, 0x3A, 0x3D and 0x3E are the 24-bit space. Codes 0x09, 0x0A, 0x0D and 0x0E are the 32-bit space. Every other code produces no hit, no inward mapping and no configuration select on either side.
- R2: Before comparison the address is truncated to the width of its space (16, 24 or 32 bits). Window w hits when the space matches and (truncated address & mask[w]) == base[w]. Window 0 is the 32-bit window, window 1 is the 24-bit window and window 2 is the 16-bit window. A change to a base or mask applies to the next access.
- R3: A 16-bit space access with truncated address bits [15:14] == 2'b11 asserts the configuration select on its side. On the local side it never asserts the outward direction, and on the remote side it never asserts the inward direction, whatever the windows hold.
- R4: The 16-bit window can hit only in the lower 48 KB (0x0000 to 0xBFFF). If its range overlaps the configuration window, configuration takes priority.
- R5: A remote access maps inward when its space is supported, it is not a configuration access, and the window of its space does not hit. The remote hit vector then marks that space.
- R6: Both hit vectors use the same encoding: bit 0 is the 32-bit space, bit 1 the 24-bit space, bit 2 the 16-bit space and bit 3 configuration. At most one bit is set. The direction output is the OR of bits 2:0, and the configuration select equals bit 3.
- R7: Each side's outputs reflect the access sampled with its strobe at the previous rising clock edge. A cycle with the strobe low gives a decode-valid of 0 and all of that side's outputs at 0 in the next cycle.
- R8: While reset is asserted, all outputs are 0. The local and remote sides decode independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| locValid | input | 1 | Local access strobe |
| locAddr | input | 32 | Local address |
| locAm | input | 6 | Local address modifier |
| remValid | input | 1 | Remote access strobe |
| remAddr | input | 32 | Remote address |
| remAm | input | 6 | Remote address modifier |
| winBase | input | 3x32 | Window bases (0: 32-bit, 1: 24-bit, 2: 16-bit) |
| winMask | input | 3x32 | Window masks (same order) |
| locHit | output | 4 | Local hit vector |
| locOutward | output | 1 | Local access maps outward |
| locCfgSel | output | 1 | Local access selects configuration space |
| locDecValid | output | 1 | Local decode result valid |
| remHit | output | 4 | Remote hit vector |
| remInward | output | 1 | Remote access maps inward |
| remCfgSel | output | 1 | Remote access selects configuration space |
| remDecValid | output | 1 | Remote decode result valid |

## Verification
The bench uses the default parameters: 32-bit addresses, a 16-bit short space, a 24-bit standard space and a 14-bit configuration size. With these values the whole 16-bit space can be swept address by address, on both sides at once, with junk in the upper address bits. The 24-bit and 32-bit spaces are swept at strides that cross every window edge. All 64 modifier codes are applied against each window. The 16-bit window is also reprogrammed to overlap the configuration region, which shows that configuration takes priority.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  localparam int NUM_WIN = 3;

  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_A16  = 2'd1,
    SP_A24  = 2'd2,
    SP_A32  = 2'd3
  } space_e;

  typedef struct packed {
    logic   locLoad;
    logic   remLoad;
    space_e locSpace;
    space_e remSpace;
  } ctrl_t;

  function automatic space_e spaceOfWin(input int w);
    case (w)
      0:       return SP_A32;
      1:       return SP_A24;
      default: return SP_A16;
    endcase
  endfunction

endpackage

// File: rtl/bwd_ctrl.sv
module bwd_ctrl
  import bwd_pkg::*;
(
  input  logic       locValid,
  input  logic [5:0] locAm,
  input  logic       remValid,
  input  logic [5:0] remAm,
  output ctrl_t      ctrl
);

  function automatic space_e amDecode(input logic [5:0] am);
    case (am)
      6'h29, 6'h2D:               return SP_A16;
      6'h39, 6'h3A, 6'h3D, 6'h3E: return SP_A24;
      6'h09, 6'h0A, 6'h0D, 6'h0E: return SP_A32;
      default:                    return SP_NONE;
    endcase
  endfunction

  always_comb begin
    ctrl.locLoad  = locValid;
    ctrl.remLoad  = remValid;
    ctrl.locSpace = amDecode(locAm);
    ctrl.remSpace = amDecode(remAm);
  end

endmodule

// File: rtl/bwd_datapath.sv
module bwd_datapath
  import bwd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int A16_W    = 16,
  parameter int A24_W    = 24,
  parameter int CFG_LOG2 = 14
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctrl_t                            ctrl,
  input  logic [ADDR_W-1:0]                locAddr,
  input  logic [ADDR_W-1:0]                remAddr,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]   winBase,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]   winMask,
  output logic [NUM_WIN:0]                 locHitQ,
  output logic [NUM_WIN:0]                 remHitQ,
  output logic                             locVldQ,
  output logic                             remVldQ
);

  localparam logic [ADDR_W-1:0] A16_MASK = {ADDR_W{1'b1}} >> (ADDR_W - A16_W);
  localparam logic [ADDR_W-1:0] A24_MASK = {ADDR_W{1'b1}} >> (ADDR_W - A24_W);
  localparam int                CFG_BITS = A16_W - CFG_LOG2;

  function automatic logic [ADDR_W-1:0] truncAddr(input logic [ADDR_W-1:0] a,
                                                  input space_e sp);
    case (sp)
      SP_A16:  return a & A16_MASK;
      SP_A24:  return a & A24_MASK;
      default: return a;
    endcase
  endfunction

  logic [ADDR_W-1:0]  locTrunc, remTrunc;
  logic               locCfg, remCfg;
  logic [NUM_WIN-1:0] locMatch, remMatch, remInHot;
  logic               remIn;
  logic [NUM_WIN:0]   locHitNext, remHitNext;

  assign locTrunc = truncAddr(locAddr, ctrl.locSpace);
  assign remTrunc = truncAddr(remAddr, ctrl.remSpace);

  assign locCfg = (ctrl.locSpace == SP_A16) &&
                  (locTrunc[A16_W-1:CFG_LOG2] == {CFG_BITS{1'b1}});
  assign remCfg = (ctrl.remSpace == SP_A16) &&
                  (remTrunc[A16_W-1:CFG_LOG2] == {CFG_BITS{1'b1}});

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam space_e WIN_SP = spaceOfWin(w);
    // The configuration region is carved out of the short window only.
    localparam bit CFG_CARVE = (WIN_SP == SP_A16);

    assign locMatch[w] = (ctrl.locSpace == WIN_SP) &&
                         ((locTrunc & winMask[w]) == winBase[w]) &&
                         !(CFG_CARVE && locCfg);
    assign remMatch[w] = (ctrl.remSpace == WIN_SP) &&
                         ((remTrunc & winMask[w]) == winBase[w]) &&
                         !(CFG_CARVE && remCfg);
    assign remInHot[w] = remIn && (ctrl.remSpace == WIN_SP);
  end

  // Inward is the complement of the outward window within the same space.
  assign remIn = (ctrl.remSpace != SP_NONE) && !remCfg && !(|remMatch);

  assign locHitNext = {locCfg, locMatch};
  assign remHitNext = {remCfg, remInHot};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locHitQ <= '0;
      remHitQ <= '0;
      locVldQ <= 1'b0;
      remVldQ <= 1'b0;
    end else begin
      locVldQ <= ctrl.locLoad;
      remVldQ <= ctrl.remLoad;
      locHitQ <= ctrl.locLoad ? locHitNext : '0;
      remHitQ <= ctrl.remLoad ? remHitNext : '0;
    end
  end

endmodule

// File: rtl/bus_window_decoder.sv
module bus_window_decoder
  import bwd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int A16_W    = 16,
  parameter int A24_W    = 24,
  parameter int CFG_LOG2 = 14
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           locValid,
  input  logic [ADDR_W-1:0]              locAddr,
  input  logic [5:0]                     locAm,
  input  logic                           remValid,
  input  logic [ADDR_W-1:0]              remAddr,
  input  logic [5:0]                     remAm,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] winBase,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] winMask,
  output logic [NUM_WIN:0]               locHit,
  output logic                           locOutward,
  output logic                           locCfgSel,
  output logic                           locDecValid,
  output logic [NUM_WIN:0]               remHit,
  output logic                           remInward,
  output logic                           remCfgSel,
  output logic                           remDecValid
);

  ctrl_t ctrl;

  bwd_ctrl u_ctrl (
    .locValid (locValid),
    .locAm    (locAm),
    .remValid (remValid),
    .remAm    (remAm),
    .ctrl     (ctrl)
  );

  bwd_datapath #(
    .ADDR_W   (ADDR_W),
    .A16_W    (A16_W),
    .A24_W    (A24_W),
    .CFG_LOG2 (CFG_LOG2)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .locAddr (locAddr),
    .remAddr (remAddr),
    .winBase (winBase),
    .winMask (winMask),
    .locHitQ (locHit),
    .remHitQ (remHit),
    .locVldQ (locDecValid),
    .remVldQ (remDecValid)
  );

  assign locOutward = |locHit[NUM_WIN-1:0];
  assign locCfgSel  = locHit[NUM_WIN];
  assign remInward  = |remHit[NUM_WIN-1:0];
  assign remCfgSel  = remHit[NUM_WIN];

endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
  parameter int ADDR_W   = 32,
  parameter int A16_W    = 16,
  parameter int CFG_LOG2 = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              locValid,
  input logic [ADDR_W-1:0] locAddr,
  input logic [5:0]        locAm,
  input logic              remValid,
  input logic [ADDR_W-1:0] remAddr,
  input logic [5:0]        remAm,
  input logic [3:0]        locHit,
  input logic              locOutward,
  input logic              locCfgSel,
  input logic              locDecValid,
  input logic [3:0]        remHit,
  input logic              remInward,
  input logic              remCfgSel,
  input logic              remDecValid
);

  function automatic logic amKnown(input logic [5:0] am);
    return am inside {6'h29, 6'h2D, 6'h39, 6'h3A, 6'h3D, 6'h3E,
                      6'h09, 6'h0A, 6'h0D, 6'h0E};
  endfunction

  function automatic logic amShort(input logic [5:0] am);
    return am inside {6'h29, 6'h2D};
  endfunction

  logic locTop, remTop;
  assign locTop = &locAddr[A16_W-1:CFG_LOG2];
  assign remTop = &remAddr[A16_W-1:CFG_LOG2];

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(locHit) && $onehot0(remHit)); // R6

  AST_LOC_CFG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    locCfgSel |-> !locOutward); // R3

  AST_REM_CFG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    remCfgSel |-> !remInward); // R3

  AST_LOC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !locValid |=> (locHit == 4'd0) && !locDecValid); // R7

  AST_REM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !remValid |=> (remHit == 4'd0) && !remDecValid); // R7

  AST_LOC_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    locValid |=> locDecValid); // R7

  AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (locValid && !amKnown(locAm)) |=> (locHit == 4'd0)); // R1

  AST_SHORT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (locValid && amShort(locAm) && locTop) |=> (locCfgSel && !locOutward)); // R4

  AST_REM_CFG_REGION: assert property (@(posedge clk) disable iff (!rstN)
    (remValid && amShort(remAm) && remTop) |=> (remCfgSel && !remInward)); // R3

endmodule

bind bus_window_decoder bwd_checker #(
  .ADDR_W   (ADDR_W),
  .A16_W    (A16_W),
  .CFG_LOG2 (CFG_LOG2)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .locValid    (locValid),
  .locAddr     (locAddr),
  .locAm       (locAm),
  .remValid    (remValid),
  .remAddr     (remAddr),
  .remAm       (remAm),
  .locHit      (locHit),
  .locOutward  (locOutward),
  .locCfgSel   (locCfgSel),
  .locDecValid (locDecValid),
  .remHit      (remHit),
  .remInward   (remInward),
  .remCfgSel   (remCfgSel),
  .remDecValid (remDecValid)
);

// File: tb/sim_bus_window_decoder.sv
`timescale 1ns/1ps
module sim_bus_window_decoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic locValid = 1'b0, remValid = 1'b0;
  logic [31:0] locAddr = '0, remAddr = '0;
  logic [5:0] locAm = '0, remAm = '0;
  logic [2:0][31:0] winBase, winMask;
  logic [3:0] locHit, remHit;
  logic locOutward, locCfgSel, locDecValid, remInward, remCfgSel, remDecValid;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_window_decoder u0 (
    .clk(clk), .rstN(rstN),
    .locValid(locValid), .locAddr(locAddr), .locAm(locAm),
    .remValid(remValid), .remAddr(remAddr), .remAm(remAm),
    .winBase(winBase), .winMask(winMask),
    .locHit(locHit), .locOutward(locOutward), .locCfgSel(locCfgSel),
    .locDecValid(locDecValid),
    .remHit(remHit), .remInward(remInward), .remCfgSel(remCfgSel),
    .remDecValid(remDecValid)
  );

  // Model: {decValid, cfgSel, direction, hit[3:0]}
  function automatic logic [6:0] expSide(input bit isRem, input logic [31:0] a,
                                         input logic [5:0] am, input bit v);
    int sp;
    logic [31:0] ta;
    logic cfg;
    logic [2:0] m;
    logic [3:0] hit;
    logic dir;
    if (!v) return 7'd0;
    case (am)
      6'h29, 6'h2D:               sp = 1;
      6'h39, 6'h3A, 6'h3D, 6'h3E: sp = 2;
      6'h09, 6'h0A, 6'h0D, 6'h0E: sp = 3;
      default:                    sp = 0;
    endcase
    ta = (sp == 1) ? (a % 32'h1_0000) : (sp == 2) ? (a % 32'h100_0000) : a;
    cfg = (sp == 1) && (ta >= 32'hC000);
    for (int w = 0; w < 3; w++)
      m[w] = (sp == 3 - w) && ((ta & winMask[w]) == winBase[w]) && !cfg;
    if (!isRem) begin
      hit = {cfg, m};
      dir = |m;
    end else begin
      dir = (sp != 0) && !cfg && (m == 3'b000);
      hit = {cfg, 3'b000};
      if (dir) hit[3 - sp] = 1'b1;
    end
    return {1'b1, cfg, dir, hit};
  endfunction

  task automatic runVec(input logic [31:0] la, input logic [5:0] lam, input bit lv,
                        input logic [31:0] ra, input logic [5:0] ram, input bit rv,
                        input string req);
    logic [6:0] eL, eR, gL, gR;
    locAddr = la; locAm = lam; locValid = lv;
    remAddr = ra; remAm = ram; remValid = rv;
    eL = expSide(1'b0, la, lam, lv);
    eR = expSide(1'b1, ra, ram, rv);
    @(negedge clk);
    gL = {locDecValid, locCfgSel, locOutward, locHit};
    gR = {remDecValid, remCfgSel, remInward, remHit};
    nChecks++;
    if (gL !== eL) begin
      nFails++;
      $display("FAIL %s local addr=%h am=%h v=%0d: got %b expected %b", req, la, lam, lv, gL, eL);
    end
    nChecks++;
    if (gR !== eR) begin
      nFails++;
      $display("FAIL %s remote addr=%h am=%h v=%0d: got %b expected %b", req, ra, ram, rv, gR, eR);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    winBase[0] = 32'h2000_0000; winMask[0] = 32'hF000_0000;
    winBase[1] = 32'h0040_0000; winMask[1] = 32'h00C0_0000;
    winBase[2] = 32'h0000_4000; winMask[2] = 32'h0000_C000;
    locValid = 1'b1; remValid = 1'b1; locAm = 6'h29; remAm = 6'h29;
    locAddr = 32'h0000_C000; remAddr = 32'h0000_4000;
    repeat (3) @(negedge clk);
    // R8: reset holds every output low even with strobes active
    nChecks++;
    if ({locHit, locOutward, locCfgSel, locDecValid,
         remHit, remInward, remCfgSel, remDecValid} !== 14'd0) begin
      nFails++;
      $display("FAIL R8 reset outputs: got %b expected 0",
               {locHit, locOutward, locCfgSel, locDecValid,
                remHit, remInward, remCfgSel, remDecValid});
    end
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R8: full short-space sweep, junk upper bits, remote on a different address
    for (int a = 0; a < 65536; a++)
      runVec(32'hABCD_0000 | a, 6'h29, 1'b1, 32'h5A5A_0000 | (a ^ 32'h8000), 6'h2D, 1'b1, "R2_R3_R4_R5_R8");

    // R2 R5: standard space at 4 KB stride, upper byte junk
    for (int a = 0; a < 32'h100_0000; a += 32'h1000)
      runVec(32'h7E00_0000 | a, 6'h39, 1'b1, 32'h1100_0000 | (a ^ 32'h40_0000), 6'h3E, 1'b1, "R2_R5");

    // R2 R5: long space at 16 MB stride with offsets
    for (int a = 0; a < 256; a++)
      runVec((a << 24) | 32'h0012_3456, 6'h0D, 1'b1, (a << 24) | 32'h00FF_FFFF, 6'h0A, 1'b1, "R2_R5");

    // R1: every modifier code against addresses inside each window and the configuration region
    for (int c = 0; c < 64; c++) begin
      runVec(32'h2040_4010, 6'(c), 1'b1, 32'h0000_C100, 6'(c), 1'b1, "R1");
      runVec(32'h0000_C200, 6'(c), 1'b1, 32'h2040_4010, 6'(c), 1'b1, "R1");
      runVec(32'h0040_5000, 6'(c), 1'b1, 32'h3000_1000, 6'(c), 1'b1, "R1");
    end

    // R7: strobe low after hitting accesses clears outputs in the next cycle
    for (int k = 0; k < 8; k++) begin
      runVec(32'h0000_4000 + k, 6'h29, 1'b1, 32'h0000_C000 + k, 6'h29, 1'b1, "R7");
      runVec(32'h0000_4000 + k, 6'h29, 1'b0, 32'h0000_C000 + k, 6'h29, k[0], "R7");
    end

    // R3 R4: short window moved over the configuration region; configuration wins
    winBase[2] = 32'h0000_C000;
    for (int a = 32'h8000; a < 32'h1_0000; a += 32'h100)
      runVec(a, 6'h2D, 1'b1, a + 32'h80, 6'h29, 1'b1, "R3_R4");

    // R2: reprogrammed long window takes effect on the next access
    winBase[0] = 32'h8000_0000; winMask[0] = 32'h8000_0000;
    for (int a = 0; a < 16; a++)
      runVec(a << 28, 6'h09, 1'b1, a << 28, 6'h0E, 1'b1, "R2");

    locValid = 1'b0; remValid = 1'b0;
    @(negedge clk);
    finishRun();
  end

endmodule